// File: doc/BRIEF.md
# Multichannel TDM Serial Output Formatter

This block turns a set of eight 24-bit conversion results into a serial bit stream, clocked by the serial clock. A data-ready pulse captures the words together with a power-down mask and the format code. The block then shifts the captured data out in one of three layouts:

- **Fixed-slot TDM** keeps every channel in its own slot.
- **Compacted TDM** drops the slots of powered-down channels and packs the remaining channels together.
- **Discrete** mode gives each channel its own output pin.

In both TDM layouts, a serial input can be chained behind the local words so that several formatters share one line. The block sits between the conversion core and the pins. Every register in it toggles on the falling edge of the serial clock, so a receiver can sample the output on the rising edge.

Top module: `tdm_out_formatter`

## Requirements
- R1: While `rst_n` is low, every `dout` bit is 0. After reset, `dout` stays 0 until the first capture.
- R2: `load`, `fmt`, `ch_data`, `pd_mask` and `din` are sampled on falling `sclk` edges.
  - At the edge where `load` is 1, position 0 of the new stream appears, and each later falling edge advances one position.
  - Words leave MSB first. Channel 1 is `ch_data[23:0]` and channel k is `ch_data[24k-1:24k-24]`.
  - `pd_mask` bit k-1 set to 1 means channel k is powered down.
- R3: With `fmt` 001 or 100 (fixed TDM), `dout[0]` carries slot k = channel k+1 for k = 0..7. That is 192 positions, and a powered-down channel's 24 positions are 0.
- R4: With `fmt` 000 or 011 (compacted TDM), `dout[0]` carries only the active channels in ascending channel order, with no gaps. That gives L = 24 × (active count) positions.
- R5: In both TDM formats, `dout[7:1]` is 0.
- R6: With `fmt` 010 or 101 (discrete), `dout[i]` carries channel i+1 MSB first for positions 0..23 and is 0 from position 24 on. A powered-down channel's pin is 0 throughout.
- R7: In TDM, the `din` value sampled at the m-th falling edge after the capture edge appears on `dout[0]` at position L+m-1. L is 192 for fixed TDM and 24 × (active count) for compacted TDM. When no channel is active in compacted TDM, it appears at position m. Only the first CHAIN_BITS such bits are passed on. `din` has no effect in discrete mode.
- R8: Once the local and chained bits are used up, `dout[0]` stays 0 until the next capture.
- R9: With `fmt` 110 or 111, all `dout` bits are 0, whatever `din` and the data do.
- R10: Changes to `fmt`, `ch_data` and `pd_mask` between captures do not affect the stream in progress.
- R11: A capture during a stream abandons it and restarts at position 0 with the new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; all state updates on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Data-ready pulse that captures a new set of words |
| fmt | input | 3 | Output format code |
| ch_data | input | NCH*WIDTH | Channel words, channel 1 in the low bits |
| pd_mask | input | NCH | Power-down flag per channel, 1 = down |
| din | input | 1 | Daisy-chain serial input |
| dout | output | NCH | Serial outputs; bit 0 carries TDM, all bits used in discrete mode |

## Verification
The assertions assume the following about the inputs:
- `load`, `fmt`, `pd_mask` and `din` are settled around each falling `sclk` edge.
- A capture marks position 0 of a fresh stream.

The checker keeps its own copy of the captured format and mask, plus a saturating position count. Its properties follow from those and from the outputs alone.

The bench keeps within these assumptions:
- It drives every input a quarter period after a falling edge and samples `dout` at the same point.
- Captures last exactly one falling edge.
- It changes format or mask only after the capture edge, when the scramble test checks that they are ignored.

// File: rtl/tdm_out_formatter.sv
module tdm_out_formatter #(
  parameter int NCH        = 8,
  parameter int WIDTH      = 24,
  parameter int CHAIN_BITS = 192
) (
  input  logic                 sclk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [2:0]           fmt,
  input  logic [NCH*WIDTH-1:0] ch_data,
  input  logic [NCH-1:0]       pd_mask,
  input  logic                 din,
  output logic [NCH-1:0]       dout
);

  localparam int TOT = NCH * WIDTH;
  localparam int IW  = $clog2(TOT + 1);
  localparam int CW  = $clog2(CHAIN_BITS + 1);

  typedef enum logic [1:0] {M_IDLE, M_DYN, M_FIX, M_DISC} mode_t;

  mode_t           mode_d, mode_q;
  logic [TOT-1:0]  sreg, packed_d, tdm_sh, disc_sh;
  logic [IW-1:0]   ins_d, ins_q;
  logic [CW-1:0]   chain_cnt;
  logic            chain_bit;

  always_comb begin
    case (fmt)
      3'b000, 3'b011: mode_d = M_DYN;
      3'b001, 3'b100: mode_d = M_FIX;
      3'b010, 3'b101: mode_d = M_DISC;
      default:        mode_d = M_IDLE;
    endcase
  end

  always_comb begin
    int slot;
    slot     = 0;
    packed_d = '0;
    for (int c = 0; c < NCH; c++) begin
      if (!pd_mask[c]) begin
        if (mode_d == M_DYN)
          packed_d[TOT-1-WIDTH*slot -: WIDTH] = ch_data[WIDTH*c +: WIDTH];
        else
          packed_d[TOT-1-WIDTH*c -: WIDTH] = ch_data[WIDTH*c +: WIDTH];
        slot++;
      end
    end
    if (mode_d == M_IDLE) packed_d = '0;
    if (mode_d == M_DYN)
      ins_d = (slot == 0) ? IW'(TOT - 1) : IW'(TOT - WIDTH * slot);
    else
      ins_d = '0;
  end

  assign chain_bit = (chain_cnt < CW'(CHAIN_BITS)) ? din : 1'b0;

  always_comb begin
    tdm_sh        = sreg << 1;
    tdm_sh[ins_q] = chain_bit;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    assign disc_sh[WIDTH*k +: WIDTH] = {sreg[WIDTH*k +: WIDTH-1], 1'b0};
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      sreg      <= '0;
      mode_q    <= M_IDLE;
      ins_q     <= '0;
      chain_cnt <= '0;
    end else if (load) begin
      sreg      <= packed_d;
      mode_q    <= mode_d;
      ins_q     <= ins_d;
      chain_cnt <= '0;
    end else begin
      case (mode_q)
        M_DISC:       sreg <= disc_sh;
        M_DYN, M_FIX: begin
          sreg <= tdm_sh;
          if (chain_cnt < CW'(CHAIN_BITS)) chain_cnt <= chain_cnt + CW'(1);
        end
        default:      sreg <= '0;
      endcase
    end
  end

  assign dout[0] = (mode_q == M_IDLE) ? 1'b0 : sreg[TOT-1];

  for (genvar i = 1; i < NCH; i++) begin : g_pin
    assign dout[i] = (mode_q == M_DISC) ? sreg[TOT-1-WIDTH*i] : 1'b0;
  end

endmodule

// File: rtl/tdm_out_formatter_sva.sv
module tdm_out_formatter_sva #(
  parameter int NCH        = 8,
  parameter int WIDTH      = 24,
  parameter int CHAIN_BITS = 192
) (
  input logic           sclk,
  input logic           rst_n,
  input logic           load,
  input logic [2:0]     fmt,
  input logic [NCH-1:0] pd_mask,
  input logic [NCH-1:0] dout
);

  localparam int TOT = NCH * WIDTH;
  localparam int LIM = TOT + CHAIN_BITS;
  localparam int NW  = $clog2(LIM + 1);
  localparam logic [1:0] K_IDLE = 2'd0, K_DYN = 2'd1, K_FIX = 2'd2, K_DISC = 2'd3;

  logic [1:0]     kind_q;
  logic [NCH-1:0] mask_q;
  logic [NW-1:0]  pos;
  logic           tdm;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_IDLE;
      mask_q <= '0;
      pos    <= '0;
    end else if (load) begin
      case (fmt)
        3'b000, 3'b011: kind_q <= K_DYN;
        3'b001, 3'b100: kind_q <= K_FIX;
        3'b010, 3'b101: kind_q <= K_DISC;
        default:        kind_q <= K_IDLE;
      endcase
      mask_q <= pd_mask;
      pos    <= '0;
    end else if (pos < NW'(LIM)) begin
      pos <= pos + NW'(1);
    end
  end

  assign tdm = (kind_q == K_DYN) || (kind_q == K_FIX);

  p_reset_quiet_r1: assert property (@(posedge sclk) !rst_n |-> dout == '0);

  p_upper_zero_r5: assert property (@(posedge sclk) disable iff (!rst_n)
    tdm |-> dout[NCH-1:1] == '0);

  p_idle_zero_r9: assert property (@(posedge sclk) disable iff (!rst_n)
    kind_q == K_IDLE |-> dout == '0);

  p_disc_down_r6: assert property (@(posedge sclk) disable iff (!rst_n)
    kind_q == K_DISC |-> (dout & mask_q) == '0);

  p_disc_tail_r6: assert property (@(posedge sclk) disable iff (!rst_n)
    (kind_q == K_DISC && pos >= NW'(WIDTH)) |-> dout == '0);

  p_fix_slot_zero_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    (kind_q == K_FIX && pos < NW'(TOT) && mask_q[int'(pos) / WIDTH]) |-> !dout[0]);

  p_tail_zero_r8: assert property (@(posedge sclk) disable iff (!rst_n)
    (tdm && pos >= NW'(LIM)) |-> !dout[0]);

endmodule

bind tdm_out_formatter tdm_out_formatter_sva #(
  .NCH(NCH), .WIDTH(WIDTH), .CHAIN_BITS(CHAIN_BITS)
) u_sva (
  .sclk(sclk), .rst_n(rst_n), .load(load), .fmt(fmt),
  .pd_mask(pd_mask), .dout(dout)
);

// File: tb/tdm_out_formatter_tb.sv
module tdm_out_formatter_tb;
  localparam int NCH = 8, W = 24, CHB = 192, TOT = NCH * W, NPOS = TOT + CHB + 8;
  localparam int NV = 10;
  // {fmt, mask, seed, expected active slots}
  localparam logic [22:0] VEC [NV] = '{
    {3'b001, 8'h00, 8'h11, 4'd8},
    {3'b100, 8'h0A, 8'h23, 4'd8},
    {3'b000, 8'h00, 8'h35, 4'd8},
    {3'b011, 8'h05, 8'h47, 4'd6},
    {3'b000, 8'hF0, 8'h59, 4'd4},
    {3'b010, 8'h00, 8'h6B, 4'd8},
    {3'b101, 8'h81, 8'h7D, 4'd6},
    {3'b110, 8'h00, 8'h8F, 4'd0},
    {3'b000, 8'hFF, 8'h91, 4'd0},
    {3'b011, 8'h7F, 8'hA3, 4'd1}
  };

  logic sclk = 0, rst_n = 0, load = 0, din = 0;
  logic [2:0] fmt = 3'b000;
  logic [TOT-1:0] ch_data = '0;
  logic [NCH-1:0] pd_mask = '0;
  logic [NCH-1:0] dout;
  int checks = 0, errors = 0;

  always #4 sclk = ~sclk;

  tdm_out_formatter #(.NCH(NCH), .WIDTH(W), .CHAIN_BITS(CHB)) u_dut (
    .sclk(sclk), .rst_n(rst_n), .load(load), .fmt(fmt), .ch_data(ch_data),
    .pd_mask(pd_mask), .din(din), .dout(dout)
  );

  function automatic logic [W-1:0] word(input logic [7:0] s, input int c);
    logic [7:0] a;
    a = s + 8'(c * 29);
    return {a, a ^ 8'hA5, 8'(a * 3 + c)};
  endfunction

  function automatic logic din_of(input int m, input logic [7:0] s);
    logic [15:0] v;
    v = 16'(m * 13 + s * 7);
    return ^(v & 16'h2D6);
  endfunction

  function automatic logic exp_bit(input logic [2:0] f, input logic [7:0] m, input logic [7:0] s,
                                   input int slots, input int n, input int lane);
    bit dyn, fix, disc;
    int len, sl, b, ch, cnt, k;
    dyn  = (f == 3'b000 || f == 3'b011);
    fix  = (f == 3'b001 || f == 3'b100);
    disc = (f == 3'b010 || f == 3'b101);
    if (disc) return (!m[lane] && n < W) ? word(s, lane)[W-1-n] : 1'b0;
    if (!(dyn || fix) || lane != 0) return 1'b0;
    len = fix ? TOT : W * slots;
    if (n < len) begin
      sl = n / W; b = n % W; ch = -1; cnt = 0;
      if (fix) ch = sl;
      else for (int c = 0; c < NCH; c++) if (!m[c]) begin
        if (cnt == sl) ch = c;
        cnt++;
      end
      if (ch < 0 || (fix && m[ch])) return 1'b0;
      return word(s, ch)[W-1-b];
    end
    k = (len == 0) ? n : n - len + 1;
    return (k >= 1 && k <= CHB) ? din_of(k, s) : 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [2:0] f, input logic [7:0] m, input logic [7:0] s,
                           input int slots, input int npos, input bit scramble, input string req);
    int bad, fpos, flane, fact, fexp;
    logic e;
    fmt = f; pd_mask = m;
    for (int c = 0; c < NCH; c++) ch_data[W*c +: W] = word(s, c);
    load = 1; din = 0;
    @(negedge sclk); #2;
    load = 0;
    if (scramble) begin
      fmt = 3'b110; pd_mask = ~m; ch_data = ~ch_data;
    end
    bad = 0; fpos = -1; flane = 0; fact = 0; fexp = 0;
    for (int n = 0; n < npos; n++) begin
      for (int lane = 0; lane < NCH; lane++) begin
        e = exp_bit(f, m, s, slots, n, lane);
        if (dout[lane] !== e) begin
          if (bad == 0) begin fpos = n; flane = lane; fact = int'(dout[lane]); fexp = int'(e); end
          bad++;
        end
      end
      din = din_of(n + 1, s);
      @(negedge sclk); #2;
    end
    check(bad == 0, req, $sformatf("fmt=%b mask=%h first bad pos=%0d lane=%0d", f, m, fpos, flane),
          fact, fexp);
  endtask

  initial begin
    repeat (150000) @(posedge sclk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset holds outputs low even with captures requested
    fmt = 3'b010; pd_mask = '0;
    for (int c = 0; c < NCH; c++) ch_data[W*c +: W] = 24'hFFFFFF;
    load = 1; din = 1;
    repeat (3) @(negedge sclk);
    #2;
    check(dout == '0, "R1", "dout under reset", int'(dout), 0);
    rst_n = 1; load = 0;
    repeat (4) @(negedge sclk);
    #2;
    check(dout == '0, "R1", "dout before first capture", int'(dout), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [2:0] f;
      string req;
      f = VEC[v][22:20];
      if (f == 3'b001 || f == 3'b100) req = "R2 R3 R5 R7 R8";
      else if (f == 3'b000 || f == 3'b011) req = "R2 R4 R5 R7 R8";
      else if (f == 3'b010 || f == 3'b101) req = "R2 R6 R7";
      else req = "R9";
      run_frame(f, VEC[v][19:12], VEC[v][11:4], int'(VEC[v][3:0]), NPOS, 1'b0, req);
    end

    // R10: inputs changed right after capture leave the stream untouched
    run_frame(3'b011, 8'h24, 8'hC5, 6, NPOS, 1'b1, "R10");
    run_frame(3'b101, 8'h10, 8'hD7, 7, 40, 1'b1, "R10");

    // R11: capture in mid-stream restarts at position 0
    run_frame(3'b001, 8'h00, 8'hE9, 8, 50, 1'b0, "R11");
    run_frame(3'b000, 8'h42, 8'hFB, 6, NPOS, 1'b0, "R11");

    // R9: modulator code 111 also idle
    run_frame(3'b111, 8'h00, 8'h3C, 0, 60, 1'b0, "R9");

    // R8: long after exhaustion output is still zero
    repeat (20) @(negedge sclk);
    #2;
    check(dout == '0, "R8", "dout after stream exhausted", int'(dout), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule